// File: doc/BRIEF.md
# Clock Source Switch Controller

This block sequences a change of the system clock from one oscillator to another. Software places a target source code next to the code of the source now in use and raises a switch request. The controller then decides whether the move is needed and allowed. It turns on whatever the target needs and waits until that hardware reports it is usable. It lets the candidate clock run for a fixed number of cycles, then asks a glitch-free clock multiplexer to hand over. Once the multiplexer confirms, it reports completion and powers down the previous source, subject to a small keep-alive policy.

Readiness comes from two inputs: an expired start-up timer for crystal sources and a lock indication for the PLL. The candidate clock is seen only through a level that flips once per candidate cycle. That level is re-timed into the system domain, so the settle count and the completion status are both already synchronous where the register fields are written.

Source codes: 0 fast RC, 1 fast RC through PLL, 2 primary crystal, 3 primary crystal through PLL, 4 secondary crystal, 5 low-power RC, 6 and 7 divided fast RC. Oscillator enable bits: [0] fast RC, [1] primary, [2] secondary, [3] low-power RC, [4] PLL.

Top module: `clksw_ctrl`

## Requirements
- R1: When a request carries a target code equal to the current code, `swen_clr` pulses for one cycle. No lock or fail clear occurs, `cur_upd` stays low, and `osc_en` and `mux_sel` keep their values.
- R2: An accepted request (target differs from current and is not forbidden) pulses `lock_clr` and `fail_clr` together for one cycle.
- R3: On acceptance, the enable bits the target needs are set. If the target is a crystal source (codes 2, 3, 4) whose crystal enable was off, `mux_sel` does not change before `ost_expired` is high.
- R4: If the target uses the PLL (codes 1, 3), the PLL enable is set and `mux_sel` does not change before `pll_locked` is high.
- R5: After readiness, `mux_sel` takes the target code only once `SETTLE_CYCLES` (default 10) toggles of `cand_toggle` have been seen, and not after 9.
- R6: After `mux_ack`, `swen_clr` and `cur_upd` pulse together in the same cycle, with `cur_upd_val` equal to the target code.
- R7: At completion, `osc_en` becomes exactly what the target needs. The low-power RC bit is kept if it was on and `wdt_fscm_on` is high, and the secondary bit is kept if it was on and `sosc_hold` is high.
- R8: A request between codes 1 and 3 (either direction) is refused. `swen_clr`, `lock_clr` and `cur_upd` stay low, `osc_en` and `mux_sel` are unchanged, and the controller waits for `swen` to drop.
- R9: After reset, `osc_en` is 5'b00001, `mux_sel` is 0 and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| swen | input | 1 | Switch-enable bit as set by software |
| new_src | input | 3 | Requested source code |
| cur_src | input | 3 | Current-source field |
| wdt_fscm_on | input | 1 | Watchdog or fail-safe monitor enabled |
| sosc_hold | input | 1 | Secondary oscillator enable bit from software |
| ost_expired | input | 1 | Crystal start-up timer has expired |
| pll_locked | input | 1 | PLL reports lock |
| cand_toggle | input | 1 | Flips once per candidate-clock cycle |
| mux_ack | input | 1 | Clock multiplexer reports handover complete |
| osc_en | output | 5 | Oscillator enables |
| mux_sel | output | 3 | Source code selected at the clock multiplexer |
| swen_clr | output | 1 | One-cycle clear of the switch-enable bit |
| cur_upd | output | 1 | One-cycle write strobe for the current-source field |
| cur_upd_val | output | 3 | Value written to the current-source field |
| lock_clr | output | 1 | One-cycle clear of the lock flag |
| fail_clr | output | 1 | One-cycle clear of the clock-fail flag |

## Verification
The bench walks a chain of switches in which each target is chosen to isolate one gating path. A move to a cold crystal is held back only by the start-up timer. A move from a running crystal to its PLL mode waits only on lock, with the timer input left low, which separates "crystal already running" from "crystal cold". Moves to an RC source wait on neither. Redundant and PLL-to-PLL requests, tried in both directions, tell an abort that clears the enable apart from one that leaves it set. Keep-alive is shown by ending switches with the watchdog and secondary-hold inputs in different combinations, and the settle count is probed at 9 and at 10 candidate toggles.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    typedef enum logic [2:0] {
        SRC_FRC       = 3'd0,
        SRC_FRC_PLL   = 3'd1,
        SRC_PRI       = 3'd2,
        SRC_PRI_PLL   = 3'd3,
        SRC_SEC       = 3'd4,
        SRC_LPRC      = 3'd5,
        SRC_FRC_DIV_A = 3'd6,
        SRC_FRC_DIV_B = 3'd7
    } src_e;

    // bit order: [4] pll, [3] lprc, [2] sec, [1] pri, [0] frc
    typedef struct packed {
        logic pll;
        logic lprc;
        logic sec;
        logic pri;
        logic frc;
    } osc_en_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READY_WAIT,
        ST_SETTLE,
        ST_HANDOVER,
        ST_HOLD
    } sw_state_e;

    function automatic osc_en_t src_need(src_e s);
        osc_en_t n;
        n = '0;
        case (s)
            SRC_FRC_PLL: begin n.frc = 1'b1; n.pll = 1'b1; end
            SRC_PRI:     n.pri = 1'b1;
            SRC_PRI_PLL: begin n.pri = 1'b1; n.pll = 1'b1; end
            SRC_SEC:     n.sec = 1'b1;
            SRC_LPRC:    n.lprc = 1'b1;
            default:     n.frc = 1'b1;
        endcase
        return n;
    endfunction

    function automatic logic is_xtal(src_e s);
        return (s == SRC_PRI) || (s == SRC_PRI_PLL) || (s == SRC_SEC);
    endfunction

    function automatic logic xtal_on(src_e s, osc_en_t en);
        return (s == SRC_SEC) ? en.sec : en.pri;
    endfunction

    function automatic logic uses_pll(src_e s);
        return (s == SRC_FRC_PLL) || (s == SRC_PRI_PLL);
    endfunction

    function automatic logic pll_cross(src_e a, src_e b);
        return ((a == SRC_PRI_PLL) && (b == SRC_FRC_PLL)) ||
               ((a == SRC_FRC_PLL) && (b == SRC_PRI_PLL));
    endfunction

    function automatic osc_en_t retain(src_e tgt, osc_en_t old, logic wdt, logic sosc);
        osc_en_t r;
        r = src_need(tgt);
        r.lprc = r.lprc | (wdt & old.lprc);
        r.sec  = r.sec  | (sosc & old.sec);
        return r;
    endfunction

endpackage

// File: rtl/clksw_tick_sync.sv
module clksw_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl,
    output logic tick
);
    // sh[0..STAGES-1] synchronise, sh[STAGES] holds the previous value
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], tgl};
    end

    assign tick = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/clksw_settle_cnt.sv
module clksw_settle_cnt #(
    parameter int N = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int W = $clog2(N + 1);
    localparam logic [W-1:0] LAST = W'(N);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)         cnt <= '0;
        else if (tick && !done)  cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LAST);
endmodule

// File: rtl/clksw_fsm.sv
module clksw_fsm
    import clksw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       swen,
    input  logic [2:0] new_src,
    input  logic [2:0] cur_src,
    input  logic       wdt_fscm_on,
    input  logic       sosc_hold,
    input  logic       ost_expired,
    input  logic       pll_locked,
    input  logic       settle_done,
    input  logic       mux_ack,
    output logic       counting,
    output osc_en_t    en_q,
    output logic [2:0] sel_q,
    output logic       swen_clr,
    output logic       cur_upd,
    output logic [2:0] cur_upd_val,
    output logic       lock_clr,
    output logic       fail_clr
);
    sw_state_e state;
    src_e      tgt;
    logic      need_ost;
    src_e      req_new;
    src_e      req_cur;
    logic      src_ready;

    assign req_new   = src_e'(new_src);
    assign req_cur   = src_e'(cur_src);
    assign src_ready = (!need_ost || ost_expired) && (!uses_pll(tgt) || pll_locked);
    assign counting  = (state == ST_SETTLE);
    assign cur_upd_val = tgt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            en_q     <= '{frc: 1'b1, default: 1'b0};
            sel_q    <= SRC_FRC;
            tgt      <= SRC_FRC;
            need_ost <= 1'b0;
            swen_clr <= 1'b0;
            cur_upd  <= 1'b0;
            lock_clr <= 1'b0;
            fail_clr <= 1'b0;
        end else begin
            swen_clr <= 1'b0;
            cur_upd  <= 1'b0;
            lock_clr <= 1'b0;
            fail_clr <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (swen) begin
                        if (req_new == req_cur) begin
                            swen_clr <= 1'b1;
                            state    <= ST_HOLD;
                        end else if (pll_cross(req_cur, req_new)) begin
                            state    <= ST_HOLD;
                        end else begin
                            lock_clr <= 1'b1;
                            fail_clr <= 1'b1;
                            tgt      <= req_new;
                            need_ost <= is_xtal(req_new) && !xtal_on(req_new, en_q);
                            en_q     <= osc_en_t'(en_q | src_need(req_new));
                            state    <= ST_READY_WAIT;
                        end
                    end
                end
                ST_READY_WAIT: begin
                    if (src_ready) state <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (settle_done) begin
                        sel_q <= tgt;
                        state <= ST_HANDOVER;
                    end
                end
                ST_HANDOVER: begin
                    if (mux_ack) begin
                        en_q     <= retain(tgt, en_q, wdt_fscm_on, sosc_hold);
                        swen_clr <= 1'b1;
                        cur_upd  <= 1'b1;
                        state    <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (!swen) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
    import clksw_pkg::*;
#(
    parameter int SETTLE_CYCLES = 10,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       swen,
    input  logic [2:0] new_src,
    input  logic [2:0] cur_src,
    input  logic       wdt_fscm_on,
    input  logic       sosc_hold,
    input  logic       ost_expired,
    input  logic       pll_locked,
    input  logic       cand_toggle,
    input  logic       mux_ack,
    output logic [4:0] osc_en,
    output logic [2:0] mux_sel,
    output logic       swen_clr,
    output logic       cur_upd,
    output logic [2:0] cur_upd_val,
    output logic       lock_clr,
    output logic       fail_clr
);
    logic    cand_tick;
    logic    counting;
    logic    settle_done;
    osc_en_t en_q;

    clksw_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .tgl  (cand_toggle),
        .tick (cand_tick)
    );

    clksw_settle_cnt #(.N(SETTLE_CYCLES)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .run  (counting),
        .tick (cand_tick),
        .done (settle_done)
    );

    clksw_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .swen        (swen),
        .new_src     (new_src),
        .cur_src     (cur_src),
        .wdt_fscm_on (wdt_fscm_on),
        .sosc_hold   (sosc_hold),
        .ost_expired (ost_expired),
        .pll_locked  (pll_locked),
        .settle_done (settle_done),
        .mux_ack     (mux_ack),
        .counting    (counting),
        .en_q        (en_q),
        .sel_q       (mux_sel),
        .swen_clr    (swen_clr),
        .cur_upd     (cur_upd),
        .cur_upd_val (cur_upd_val),
        .lock_clr    (lock_clr),
        .fail_clr    (fail_clr)
    );

    assign osc_en = en_q;
endmodule

// File: rtl/clksw_ctrl_chk.sv
module clksw_ctrl_chk
    import clksw_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] cur_src,
    input logic       mux_ack,
    input logic [4:0] osc_en,
    input logic [2:0] mux_sel,
    input logic       swen_clr,
    input logic       cur_upd,
    input logic [2:0] cur_upd_val,
    input logic       lock_clr,
    input logic       settle_done
);
    p_no_redundant_upd_r1: assert property (@(posedge clk) disable iff (rst)
        cur_upd |-> (cur_upd_val != cur_src));

    p_clear_single_r2: assert property (@(posedge clk) disable iff (rst)
        lock_clr |=> !lock_clr);

    p_sel_source_enabled_r3: assert property (@(posedge clk) disable iff (rst)
        ((5'(src_need(src_e'(mux_sel))) & ~osc_en) == 5'd0));

    p_sel_after_settle_r5: assert property (@(posedge clk) disable iff (rst)
        (mux_sel != $past(mux_sel)) |-> $past(settle_done));

    p_upd_after_ack_r6: assert property (@(posedge clk) disable iff (rst)
        cur_upd |-> $past(mux_ack));

    p_upd_with_clear_r6: assert property (@(posedge clk) disable iff (rst)
        cur_upd |-> swen_clr);

    p_no_pll_cross_r8: assert property (@(posedge clk) disable iff (rst)
        cur_upd |-> !pll_cross(src_e'(cur_src), src_e'(cur_upd_val)));
endmodule

bind clksw_ctrl clksw_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cur_src     (cur_src),
    .mux_ack     (mux_ack),
    .osc_en      (osc_en),
    .mux_sel     (mux_sel),
    .swen_clr    (swen_clr),
    .cur_upd     (cur_upd),
    .cur_upd_val (cur_upd_val),
    .lock_clr    (lock_clr),
    .settle_done (settle_done)
);

// File: tb/clksw_ctrl_tb.sv
module clksw_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       swen = 1'b0;
    logic [2:0] new_src = 3'd0;
    logic [2:0] cur_src = 3'd0;
    logic       wdt_fscm_on = 1'b0;
    logic       sosc_hold = 1'b0;
    logic       ost_expired = 1'b0;
    logic       pll_locked = 1'b0;
    logic       cand_toggle = 1'b0;
    logic       mux_ack = 1'b0;
    logic [4:0] osc_en;
    logic [2:0] mux_sel;
    logic       swen_clr, cur_upd, lock_clr, fail_clr;
    logic [2:0] cur_upd_val;

    int errors = 0;
    int checks = 0;
    int ev_seen = 0;
    logic [10:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    clksw_ctrl u_dut (
        .clk(clk), .rst(rst), .swen(swen), .new_src(new_src), .cur_src(cur_src),
        .wdt_fscm_on(wdt_fscm_on), .sosc_hold(sosc_hold), .ost_expired(ost_expired),
        .pll_locked(pll_locked), .cand_toggle(cand_toggle), .mux_ack(mux_ack),
        .osc_en(osc_en), .mux_sel(mux_sel), .swen_clr(swen_clr), .cur_upd(cur_upd),
        .cur_upd_val(cur_upd_val), .lock_clr(lock_clr), .fail_clr(fail_clr)
    );

    // current-source field held by the environment
    always @(posedge clk) if (!rst && cur_upd) cur_src <= cur_upd_val;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // event word: {swclr, lock, fail, upd, updval[2:0], selchg, sel[2:0]}
    function automatic logic [10:0] mk(bit sc, bit lk, bit fl, bit up, logic [2:0] uv,
                                       bit sg, logic [2:0] sv);
        return {sc, lk, fl, up, (up ? uv : 3'd0), sg, (sg ? sv : 3'd0)};
    endfunction

    // monitor: pops the scoreboard whenever the design emits an event
    initial begin
        logic [2:0]  prev_sel;
        logic [10:0] act;
        logic [10:0] exp;
        prev_sel = 3'd0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                act = mk(swen_clr, lock_clr, fail_clr, cur_upd, cur_upd_val,
                         mux_sel != prev_sel, mux_sel);
                prev_sel = mux_sel;
                if (act != 11'd0) begin
                    ev_seen++;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8", "unexpected event", act, 0);
                    end else begin
                        exp = exp_q.pop_front();
                        chk(act == exp, exp[9] ? "R2" : (exp[3] ? "R5" : (exp[7] ? "R6" : "R1")),
                            "event", act, exp);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic cand_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            cand_toggle = ~cand_toggle;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic wait_clear(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            if (swen_clr) seen = 1'b1;
            else @(negedge clk);
        end
    endtask

    task automatic do_redundant();
        logic [4:0] en0;
        logic [2:0] sel0;
        bit seen;
        en0 = osc_en;
        sel0 = mux_sel;
        exp_q.push_back(mk(1, 0, 0, 0, 0, 0, 0));
        new_src = cur_src;
        swen = 1'b1;
        @(negedge clk);
        wait_clear(seen);
        chk(seen, "R1", "redundant clears enable", seen, 1);
        swen = 1'b0;
        repeat (3) @(negedge clk);
        chk(osc_en == en0, "R1", "enables unchanged", osc_en, en0);
        chk(mux_sel == sel0, "R1", "select unchanged", mux_sel, sel0);
    endtask

    task automatic do_forbidden(input logic [2:0] tgt);
        logic [4:0] en0;
        logic [2:0] sel0;
        int ev0;
        en0 = osc_en;
        sel0 = mux_sel;
        ev0 = ev_seen;
        new_src = tgt;
        swen = 1'b1;
        pll_locked = 1'b1;
        cand_pulses(12);
        chk(ev_seen == ev0, "R8", "no event on PLL cross", ev_seen, ev0);
        chk(osc_en == en0, "R8", "enables unchanged", osc_en, en0);
        chk(mux_sel == sel0, "R8", "select unchanged", mux_sel, sel0);
        swen = 1'b0;
        pll_locked = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_switch(input logic [2:0] tgt, input bit ost_w, input bit pll_w,
                             input logic [4:0] exp_acc, input logic [4:0] exp_fin);
        logic [2:0] old;
        bit seen;
        old = mux_sel;
        exp_q.push_back(mk(0, 1, 1, 0, 0, 0, 0));
        exp_q.push_back(mk(0, 0, 0, 0, 0, 1, tgt));
        exp_q.push_back(mk(1, 0, 0, 1, tgt, 0, 0));
        new_src = tgt;
        swen = 1'b1;
        repeat (3) @(negedge clk);
        chk(osc_en == exp_acc, "R3", "enables on accept", osc_en, exp_acc);
        if (ost_w) begin
            cand_pulses(12);
            chk(mux_sel == old, "R3", "held until start-up timer", mux_sel, old);
            ost_expired = 1'b1;
        end
        if (pll_w) begin
            cand_pulses(12);
            chk(mux_sel == old, "R4", "held until PLL lock", mux_sel, old);
            pll_locked = 1'b1;
        end
        repeat (2) @(negedge clk);
        cand_pulses(9);
        repeat (2) @(negedge clk);
        chk(mux_sel == old, "R5", "no handover after 9 cycles", mux_sel, old);
        cand_pulses(1);
        repeat (2) @(negedge clk);
        chk(mux_sel == tgt, "R5", "handover after 10 cycles", mux_sel, tgt);
        mux_ack = 1'b1;
        @(negedge clk);
        mux_ack = 1'b0;
        wait_clear(seen);
        chk(seen, "R6", "completion clears enable", seen, 1);
        swen = 1'b0;
        ost_expired = 1'b0;
        pll_locked = 1'b0;
        repeat (3) @(negedge clk);
        chk(osc_en == exp_fin, "R7", "enables after switch", osc_en, exp_fin);
        chk(cur_src == tgt, "R6", "current field updated", cur_src, tgt);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(osc_en == 5'b00001, "R9", "reset enables", osc_en, 5'b00001);
        chk(mux_sel == 3'd0, "R9", "reset select", mux_sel, 0);
        chk({swen_clr, cur_upd, lock_clr, fail_clr} == 4'd0, "R9", "reset pulses",
            {swen_clr, cur_upd, lock_clr, fail_clr}, 0);

        do_redundant();                                     // R1: 0 -> 0
        do_switch(3'd2, 1, 0, 5'b00011, 5'b00010);          // R3: cold crystal
        do_switch(3'd3, 0, 1, 5'b10010, 5'b10010);          // R4: crystal already on
        do_forbidden(3'd1);                                 // R8: 3 -> 1
        wdt_fscm_on = 1'b1;
        do_switch(3'd5, 0, 0, 5'b11010, 5'b01000);          // R7: PLL and primary off
        sosc_hold = 1'b1;
        do_switch(3'd4, 1, 0, 5'b01100, 5'b01100);          // R7: LPRC kept
        wdt_fscm_on = 1'b0;
        do_switch(3'd0, 0, 0, 5'b01101, 5'b00101);          // R7: SOSC kept, LPRC off
        sosc_hold = 1'b0;
        do_switch(3'd1, 0, 1, 5'b10101, 5'b10001);          // R4/R7: SOSC released
        do_forbidden(3'd3);                                 // R8: 1 -> 3
        do_redundant();                                     // R1: 1 -> 1

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R6", "all expected events seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule